// File: doc/BRIEF.md
# Pixel Array Readout Timing Sequencer

This block sets the readout timing for one rectangular window of a 640 x 480 pixel array. A frame start request, accepted only while the sequencer is idle, latches the whole configuration. A frame overhead interval follows. Each selected line then gets a row overhead interval and one clock for each pixel read. After the last pixel of the last line the sequencer pulses a frame-done strobe for one clock and goes back to idle.

The overhead lengths are not entered directly. A 2-bit granularity code selects them, and subsampling adds a fixed extension to every row overhead. Subsampling also makes the vertical address advance two lines per row instead of one. The horizontal window start and pixel count are forced onto 8-pixel boundaries. The window is clamped so that it never runs past the array edge.

Top module: `readout_sequencer`

## Requirements
- R1: After reset, and whenever no frame is running, frameValid, lineValid, pixelValid and frameDone are all low.
- R2: The frame overhead lasts 192, 336, 624 or 1200 clocks for granularity codes 0, 1, 2 and 3. If frameStart is high at a clock edge while idle, frameValid first goes high exactly that many clocks after that edge.
- R3: Each row begins with a row overhead of 20, 24, 32 or 48 clocks for codes 0, 1, 2 and 3, plus 8 more clocks when subsampleEn is 1. During the row overhead frameValid is high and lineValid is low.
- R4: After its row overhead, each row holds lineValid high for exactly the effective pixel count. During that time xAddr runs from the effective x start upward by 1 per clock.
- R5: The effective x start is xStart with its low 3 bits cleared, limited to at most 632. The effective pixel count is pixCount with its low 3 bits cleared. A count of 0 becomes 8, and the count is limited to 640 minus the effective x start.
- R6: The first row uses yAddr equal to yStart (limited to at most 479). Each following row adds 1, or adds 2 when subsampleEn is 1. The number of rows is lineCount (0 is treated as 1), limited so that no row address exceeds 479.
- R7: frameDone is high for exactly one clock, in the clock right after the last pixel of the last row. frameValid is low in that clock, and the block is idle in the clock after it.
- R8: Configuration inputs that change after the accepting edge do not affect the frame in progress.
- R9: A frameStart request that arrives while a frame is in progress is ignored: the running frame's timing is unchanged and no new frame follows it.
- R10: frameValid is high continuously from the first row overhead through the last pixel. pixelValid equals lineValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Request to start a frame (accepted while idle) |
| granCode | input | 2 | Overhead granularity code |
| subsampleEn | input | 1 | Subsampling mode enable |
| xStart | input | 10 | Requested window x start |
| pixCount | input | 10 | Requested pixels per line |
| yStart | input | 9 | Requested window y start |
| lineCount | input | 9 | Requested number of lines |
| frameValid | output | 1 | High from the first row overhead through the last pixel |
| lineValid | output | 1 | High during the pixel part of each row |
| pixelValid | output | 1 | High on each pixel read clock |
| xAddr | output | 10 | Current horizontal pixel address |
| yAddr | output | 9 | Current vertical line address |
| frameDone | output | 1 | One-clock pulse after the frame's last pixel |

## Verification
Small windows are swept across all four granularity codes, with subsampling both off and on. Each frame's strobes and addresses are compared clock by clock against a timeline computed from the overhead tables. This separates the frame-overhead length from the row-overhead length and the subsampling extension, and shows whether the vertical step is one line or two. Unaligned starts and counts, a zero count, windows that push past the right or bottom edge, and a clamped subsampled line count exercise the alignment and clamping rules. One frame changes every input and repeats the start request partway through; the unchanged timeline shows that the configuration was latched and the second request was ignored.

// File: rtl/readout_seq_pkg.sv
package readout_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FOT,
    ST_ROT,
    ST_PIX,
    ST_DONE
  } seqState_t;

  typedef struct packed {
    logic cfgLoad;
    logic loadY;
    logic stepY;
    logic loadX;
    logic stepX;
    logic rowPhase;
    logic pixPhase;
    logic donePhase;
  } seqStrobes_t;

  localparam int unsigned FRAME_OVH_MAX = 1200;

  function automatic int unsigned frameOvh(input logic [1:0] code);
    case (code)
      2'd3:    return 1200;
      2'd2:    return 624;
      2'd1:    return 336;
      default: return 192;
    endcase
  endfunction

  function automatic int unsigned rowOvh(input logic [1:0] code);
    case (code)
      2'd3:    return 48;
      2'd2:    return 32;
      2'd1:    return 24;
      default: return 20;
    endcase
  endfunction

endpackage

// File: rtl/readout_cfg.sv
module readout_cfg #(
  parameter int ARRAY_W = 640,
  parameter int ARRAY_H = 480,
  parameter int ALIGN   = 8,
  parameter int XW      = 10,
  parameter int YW      = 9
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          load,
  input  logic [1:0]    granIn,
  input  logic          subsIn,
  input  logic [XW-1:0] xStartIn,
  input  logic [XW-1:0] pixCountIn,
  input  logic [YW-1:0] yStartIn,
  input  logic [YW-1:0] lineCountIn,
  output logic [1:0]    granQ,
  output logic          subsQ,
  output logic [XW-1:0] xsQ,
  output logic [XW-1:0] pcQ,
  output logic [YW-1:0] ysQ,
  output logic [YW-1:0] linesQ
);

  localparam logic [XW-1:0] ALIGN_MASK = ~XW'(ALIGN - 1);
  localparam logic [XW-1:0] W_L        = XW'(ARRAY_W);
  localparam logic [XW-1:0] XS_MAX     = XW'(ARRAY_W - ALIGN);
  localparam logic [XW-1:0] ALIGN_L    = XW'(ALIGN);
  localparam logic [YW-1:0] H_L        = YW'(ARRAY_H);
  localparam logic [YW-1:0] YS_MAX     = YW'(ARRAY_H - 1);

  logic [XW-1:0] xsAl, xsC, pcAl, pcNz, roomX, pcC;
  logic [YW-1:0] ysC, lcNz, roomY, lcC;

  always_comb begin
    xsAl  = xStartIn & ALIGN_MASK;
    xsC   = (xsAl > XS_MAX) ? XS_MAX : xsAl;
    pcAl  = pixCountIn & ALIGN_MASK;
    pcNz  = (pcAl == '0) ? ALIGN_L : pcAl;
    roomX = W_L - xsC;
    pcC   = (pcNz > roomX) ? roomX : pcNz;
    ysC   = (yStartIn > YS_MAX) ? YS_MAX : yStartIn;
    lcNz  = (lineCountIn == '0) ? YW'(1) : lineCountIn;
    roomY = subsIn ? (((YS_MAX - ysC) >> 1) + YW'(1)) : (H_L - ysC);
    lcC   = (lcNz > roomY) ? roomY : lcNz;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      granQ  <= '0;
      subsQ  <= 1'b0;
      xsQ    <= '0;
      pcQ    <= ALIGN_L;
      ysQ    <= '0;
      linesQ <= YW'(1);
    end else if (load) begin
      granQ  <= granIn;
      subsQ  <= subsIn;
      xsQ    <= xsC;
      pcQ    <= pcC;
      ysQ    <= ysC;
      linesQ <= lcC;
    end
  end

endmodule

// File: rtl/readout_ctrl.sv
module readout_ctrl
  import readout_seq_pkg::*;
#(
  parameter int XW        = 10,
  parameter int YW        = 9,
  parameter int CW        = 11,
  parameter int SUB_EXTRA = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          frameStart,
  input  logic [1:0]    gran,
  input  logic          subs,
  input  logic [XW-1:0] pixLen,
  input  logic [YW-1:0] lines,
  output seqStrobes_t   strobes
);

  seqState_t     state;
  logic [CW-1:0] cnt;
  logic [YW-1:0] rowsLeft;
  logic [CW-1:0] fotLen, rotLen, curLen;
  logic          cntEnd;

  always_comb begin
    fotLen = CW'(frameOvh(gran));
    rotLen = CW'(rowOvh(gran) + (subs ? SUB_EXTRA : 0));
    case (state)
      ST_FOT:  curLen = fotLen;
      ST_ROT:  curLen = rotLen;
      ST_PIX:  curLen = CW'(pixLen);
      default: curLen = CW'(1);
    endcase
    cntEnd = (cnt == curLen - CW'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      rowsLeft <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (frameStart) state <= ST_FOT;
        end
        ST_FOT: begin
          if (cntEnd) begin
            state    <= ST_ROT;
            cnt      <= '0;
            rowsLeft <= lines - YW'(1);
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        ST_ROT: begin
          if (cntEnd) begin
            state <= ST_PIX;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        ST_PIX: begin
          if (cntEnd) begin
            cnt <= '0;
            if (rowsLeft == '0) begin
              state <= ST_DONE;
            end else begin
              state    <= ST_ROT;
              rowsLeft <= rowsLeft - YW'(1);
            end
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: begin
          state <= ST_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  always_comb begin
    strobes           = '0;
    strobes.cfgLoad   = (state == ST_IDLE) && frameStart;
    strobes.loadY     = (state == ST_FOT) && cntEnd;
    strobes.loadX     = (state == ST_ROT) && cntEnd;
    strobes.stepX     = (state == ST_PIX) && !cntEnd;
    strobes.stepY     = (state == ST_PIX) && cntEnd && (rowsLeft != '0);
    strobes.rowPhase  = (state == ST_ROT);
    strobes.pixPhase  = (state == ST_PIX);
    strobes.donePhase = (state == ST_DONE);
  end

endmodule

// File: rtl/readout_addr.sv
module readout_addr
  import readout_seq_pkg::*;
#(
  parameter int XW = 10,
  parameter int YW = 9
) (
  input  logic          clk,
  input  logic          rstN,
  input  seqStrobes_t   strobes,
  input  logic          subs,
  input  logic [XW-1:0] xsBase,
  input  logic [YW-1:0] ysBase,
  output logic [XW-1:0] xAddr,
  output logic [YW-1:0] yAddr
);

  logic [YW-1:0] yStep;

  assign yStep = subs ? YW'(2) : YW'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xAddr <= '0;
      yAddr <= '0;
    end else begin
      if (strobes.loadX)      xAddr <= xsBase;
      else if (strobes.stepX) xAddr <= xAddr + XW'(1);

      if (strobes.loadY)      yAddr <= ysBase;
      else if (strobes.stepY) yAddr <= yAddr + yStep;
    end
  end

endmodule

// File: rtl/readout_sequencer.sv
module readout_sequencer
  import readout_seq_pkg::*;
#(
  parameter int ARRAY_W   = 640,
  parameter int ARRAY_H   = 480,
  parameter int ALIGN     = 8,
  parameter int SUB_EXTRA = 8,
  localparam int XW       = $clog2(ARRAY_W + 1),
  localparam int YW       = $clog2(ARRAY_H + 1),
  localparam int CW       = $clog2(((FRAME_OVH_MAX > ARRAY_W) ? FRAME_OVH_MAX : ARRAY_W) + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          frameStart,
  input  logic [1:0]    granCode,
  input  logic          subsampleEn,
  input  logic [XW-1:0] xStart,
  input  logic [XW-1:0] pixCount,
  input  logic [YW-1:0] yStart,
  input  logic [YW-1:0] lineCount,
  output logic          frameValid,
  output logic          lineValid,
  output logic          pixelValid,
  output logic [XW-1:0] xAddr,
  output logic [YW-1:0] yAddr,
  output logic          frameDone
);

  seqStrobes_t   strobes;
  logic [1:0]    granQ;
  logic          subsQ;
  logic [XW-1:0] xsQ, pcQ;
  logic [YW-1:0] ysQ, linesQ;

  readout_cfg #(
    .ARRAY_W(ARRAY_W), .ARRAY_H(ARRAY_H), .ALIGN(ALIGN), .XW(XW), .YW(YW)
  ) i_cfg (
    .clk(clk), .rstN(rstN), .load(strobes.cfgLoad),
    .granIn(granCode), .subsIn(subsampleEn),
    .xStartIn(xStart), .pixCountIn(pixCount),
    .yStartIn(yStart), .lineCountIn(lineCount),
    .granQ(granQ), .subsQ(subsQ), .xsQ(xsQ), .pcQ(pcQ),
    .ysQ(ysQ), .linesQ(linesQ)
  );

  readout_ctrl #(
    .XW(XW), .YW(YW), .CW(CW), .SUB_EXTRA(SUB_EXTRA)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart),
    .gran(granQ), .subs(subsQ), .pixLen(pcQ), .lines(linesQ),
    .strobes(strobes)
  );

  readout_addr #(
    .XW(XW), .YW(YW)
  ) i_addr (
    .clk(clk), .rstN(rstN), .strobes(strobes), .subs(subsQ),
    .xsBase(xsQ), .ysBase(ysQ), .xAddr(xAddr), .yAddr(yAddr)
  );

  assign frameValid = strobes.rowPhase | strobes.pixPhase;
  assign lineValid  = strobes.pixPhase;
  assign pixelValid = strobes.pixPhase;
  assign frameDone  = strobes.donePhase;

endmodule

// File: rtl/readout_sequencer_chk.sv
module readout_sequencer_chk #(
  parameter int ARRAY_W = 640,
  parameter int ARRAY_H = 480,
  parameter int ALIGN   = 8,
  parameter int XW      = 10,
  parameter int YW      = 9
) (
  input logic          clk,
  input logic          rstN,
  input logic          frameValid,
  input logic          lineValid,
  input logic          pixelValid,
  input logic [XW-1:0] xAddr,
  input logic [YW-1:0] yAddr,
  input logic          frameDone
);

  p_lv_inside_fv_r10: assert property (@(posedge clk) disable iff (!rstN)
    lineValid |-> frameValid);

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone && !frameValid);

  p_done_after_pixel_r7: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> !frameValid && $past(lineValid));

  p_x_aligned_start_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lineValid) |-> (int'(xAddr) % ALIGN) == 0);

  p_x_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    lineValid && $past(lineValid) |-> xAddr == $past(xAddr) + XW'(1));

  p_x_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    lineValid |-> int'(xAddr) < ARRAY_W);

  p_y_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |-> int'(yAddr) < ARRAY_H);

  p_y_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    lineValid && $past(frameValid) |-> $stable(yAddr));

  p_pv_follows_lv_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lineValid) |-> pixelValid);

endmodule

bind readout_sequencer readout_sequencer_chk #(
  .ARRAY_W(ARRAY_W), .ARRAY_H(ARRAY_H), .ALIGN(ALIGN), .XW(XW), .YW(YW)
) i_chk (
  .clk(clk), .rstN(rstN), .frameValid(frameValid), .lineValid(lineValid),
  .pixelValid(pixelValid), .xAddr(xAddr), .yAddr(yAddr), .frameDone(frameDone)
);

// File: tb/test_readout_sequencer.sv
module test_readout_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int XW = 10;
  localparam int YW = 9;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          frameStart = 1'b0;
  logic [1:0]    granCode = '0;
  logic          subsampleEn = 1'b0;
  logic [XW-1:0] xStart = '0;
  logic [XW-1:0] pixCount = '0;
  logic [YW-1:0] yStart = '0;
  logic [YW-1:0] lineCount = '0;
  logic          frameValid, lineValid, pixelValid, frameDone;
  logic [XW-1:0] xAddr;
  logic [YW-1:0] yAddr;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;

  readout_sequencer i_readout_sequencer (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .granCode(granCode),
    .subsampleEn(subsampleEn), .xStart(xStart), .pixCount(pixCount),
    .yStart(yStart), .lineCount(lineCount), .frameValid(frameValid),
    .lineValid(lineValid), .pixelValid(pixelValid), .xAddr(xAddr),
    .yAddr(yAddr), .frameDone(frameDone)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  function automatic int fotOf(int g);
    return (g == 3) ? 1200 : (g == 2) ? 624 : (g == 1) ? 336 : 192;
  endfunction

  function automatic int rotOf(int g, int s);
    return ((g == 3) ? 48 : (g == 2) ? 32 : (g == 1) ? 24 : 20) + (s ? 8 : 0);
  endfunction

  task automatic check(string req, int actual, int expected);
    testsRun++;
    if (actual != expected) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic runFrame(int g, int s, int xs, int pc, int ys, int lc, bit alter);
    int exs, epc, eys, elc, maxL, fot, rot, total;
    int fvErr, lvErr, pvErr, xErr, yErr, dnErr;
    exs = (xs / 8) * 8;
    if (exs > 632) exs = 632;
    epc = (pc / 8) * 8;
    if (epc == 0) epc = 8;
    if (epc > 640 - exs) epc = 640 - exs;
    eys = (ys > 479) ? 479 : ys;
    elc = (lc == 0) ? 1 : lc;
    maxL = s ? ((479 - eys) / 2 + 1) : (480 - eys);
    if (elc > maxL) elc = maxL;
    fot = fotOf(g);
    rot = rotOf(g, s);
    total = fot + elc * (rot + epc);
    fvErr = 0; lvErr = 0; pvErr = 0; xErr = 0; yErr = 0; dnErr = 0;

    @(negedge clk);
    granCode = 2'(g); subsampleEn = s[0]; xStart = XW'(xs);
    pixCount = XW'(pc); yStart = YW'(ys); lineCount = YW'(lc);
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
    for (int k = 0; k <= total + 3; k++) begin
      int eFv, eLv, eX, eY, eDn, j, row, off;
      eFv = 0; eLv = 0; eX = -1; eY = -1; eDn = 0;
      if (k >= fot && k < total) begin
        j = k - fot;
        row = j / (rot + epc);
        off = j % (rot + epc);
        eFv = 1;
        eY = eys + row * (s ? 2 : 1);
        if (off >= rot) begin
          eLv = 1;
          eX = exs + off - rot;
        end
      end else if (k == total) begin
        eDn = 1;
      end
      if (int'(frameValid) != eFv) begin
        if (fvErr == 0) $display("FAIL R2 R10 k=%0d frameValid: actual %0d expected %0d", k, frameValid, eFv);
        fvErr++;
      end
      if (int'(lineValid) != eLv) begin
        if (lvErr == 0) $display("FAIL R3 R4 k=%0d lineValid: actual %0d expected %0d", k, lineValid, eLv);
        lvErr++;
      end
      if (int'(pixelValid) != eLv) begin
        if (pvErr == 0) $display("FAIL R10 k=%0d pixelValid: actual %0d expected %0d", k, pixelValid, eLv);
        pvErr++;
      end
      if (eX >= 0 && int'(xAddr) != eX) begin
        if (xErr == 0) $display("FAIL R4 R5 k=%0d xAddr: actual %0d expected %0d", k, xAddr, eX);
        xErr++;
      end
      if (eY >= 0 && int'(yAddr) != eY) begin
        if (yErr == 0) $display("FAIL R6 k=%0d yAddr: actual %0d expected %0d", k, yAddr, eY);
        yErr++;
      end
      if (int'(frameDone) != eDn) begin
        if (dnErr == 0) $display("FAIL R7 k=%0d frameDone: actual %0d expected %0d", k, frameDone, eDn);
        dnErr++;
      end
      // R8 R9: mid-frame change of every input plus a repeated start request
      if (alter && k == fot + 2) begin
        frameStart = 1'b1;
        granCode = ~granCode; subsampleEn = ~subsampleEn;
        xStart = XW'(200); pixCount = XW'(64); yStart = YW'(300); lineCount = YW'(9);
      end else begin
        frameStart = 1'b0;
      end
      @(negedge clk);
    end
    check(alter ? "R2 R10 R8 R9 frameValid mismatches" : "R2 R10 frameValid mismatches", fvErr, 0);
    check("R3 R4 lineValid mismatches", lvErr, 0);
    check("R10 pixelValid mismatches", pvErr, 0);
    check("R4 R5 xAddr mismatches", xErr, 0);
    check("R6 yAddr mismatches", yErr, 0);
    check(alter ? "R7 R9 frameDone mismatches" : "R7 frameDone mismatches", dnErr, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: quiet outputs in reset and just after release
    check("R1 frameValid in reset", int'(frameValid), 0);
    check("R1 lineValid in reset", int'(lineValid), 0);
    check("R1 frameDone in reset", int'(frameDone), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle frameValid", int'(frameValid), 0);
    check("R1 idle pixelValid", int'(pixelValid), 0);

    // R2 R3 R6: every granularity code, subsampling off and on
    for (int g = 0; g < 4; g++)
      for (int s = 0; s < 2; s++)
        runFrame(g, s, 21, 19, 5, 3, 1'b0);
    // R5 R6: zero counts, lowest corner
    runFrame(2, 0, 0, 0, 0, 0, 1'b0);
    // R5 R6: x start past edge, count clamp, subsampled line clamp
    runFrame(1, 1, 1000, 100, 478, 5, 1'b0);
    // R5 R6: right and bottom clamp in normal mode
    runFrame(0, 0, 600, 200, 470, 20, 1'b0);
    // R8 R9: configuration changed and start repeated mid-frame
    runFrame(3, 1, 40, 24, 10, 4, 1'b1);
    // R1 R9: stays idle after the ignored request
    repeat (5) @(negedge clk);
    check("R1 R9 idle after frame", int'(frameValid), 0);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule